// File: doc/BRIEF.md
# Gated Pulse Frequency Counter

This block measures the rate of an external pulse stream by counting its edges only while a measurement window is open. The window comes from a gate signal. A select input chooses either a dedicated gate pin or a gate produced elsewhere on the chip. The count is held between windows and keeps growing across them until software issues a clear. Software usually clears the count, opens a window of known length, and reads the held value after the window has closed.

Both asynchronous inputs pass through a two-flop synchronizer. A two-state window machine follows the synchronized gate:

- State `WIN_SHUT`: the window is closed and counting is halted.
- State `WIN_OPEN`: the window is open and edges are counted.
- Transition "open" goes from `WIN_SHUT` to `WIN_OPEN` when the gate is seen high.
- Transition "close" goes from `WIN_OPEN` to `WIN_SHUT` when the gate is seen low.

Closing a window always adds one final count under a rule set by the edge mode. An interrupt pulse marks every close. When selected, it also marks every open.

Top module: `gfm_counter`

## Requirements
- R1: The count is `CNT_W` bits wide, with a default of 18. Each counted edge adds exactly one, and the count never advances by more than one per clock. Incrementing from all-ones wraps the count to zero.
- R2: `ovf_flag` goes to 1 on the wrap from all-ones to zero. It stays at 1 until a clear.
- R3: A `clr` pulse sets both `count_q` and `ovf_flag` to 0 at the next clock edge. A clear that coincides with an increment wins, so holding `clr` through a whole window leaves the count at 0.
- R4: While the window machine is in `WIN_SHUT`, the count does not change except through a clear.
- R5: Without a clear, each new window continues from the value the previous window left.
- R6: `gate_sel` = 2'b00 takes the window gate from `gate_pin`. The codes 01, 10 and 11 take it from `gate_int`. The source that is not selected has no effect.
- R7: With `edge_mode` = 0, the count advances on each falling edge of (measured input AND gate). The result is one count per input pulse that lies inside the window, plus one more if the input is high when the window closes. An input held high gives 1, and an input held low gives 0.
- R8: With `edge_mode` = 1, the count advances on each rising edge of the input while the window is open, and by exactly one at every close whatever the input level. k pulses inside a window give k+1, and a constant input gives 1.
- R9: `irq` is a one-cycle pulse on every close. With `irq_both` = 1 it also pulses on every open. With `irq_both` = 0 there is no pulse on open.
- R10: `gate_lvl` is 1 exactly while the machine is in `WIN_OPEN`. It follows a change on the selected gate pin three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_in | input | 1 | Pulse stream to measure (asynchronous) |
| gate_pin | input | 1 | External window gate (asynchronous) |
| gate_int | input | 1 | Internally generated window gate |
| gate_sel | input | 2 | 00 selects gate_pin; any other code selects gate_int |
| edge_mode | input | 1 | 0: AND-falling counting; 1: rising edges plus one at close |
| irq_both | input | 1 | 1: interrupt on open and close; 0: on close only |
| clr | input | 1 | Synchronous clear of count and overflow flag |
| count_q | output | CNT_W | Held count |
| ovf_flag | output | 1 | Sticky overflow flag |
| gate_lvl | output | 1 | Current window level |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach is the wrap from all-ones. Getting there takes one full counter period of edges inside windows, and the flag must then survive a later window before it is cleared. The bench builds the design with an 8-bit count and drives single-cycle pulses through one long window, so 259 edges wrap the count to 3. A second window then checks that the flag persists and that the count continues from where it stopped. Clear priority is reached by holding `clr` through a window full of edges. The main sweep covers every gate-select code, both edge modes, both interrupt modes and 0 to 4 pulses per window. During the sweep the unselected gate source is held high, which exposes a wrong mux choice.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

    typedef enum logic [0:0] {
        WIN_SHUT = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_t;

    localparam logic [1:0] GSEL_PIN  = 2'b00;
    localparam logic       MODE_AND  = 1'b0;
    localparam logic       MODE_RISE = 1'b1;

endpackage

// File: rtl/gfm_sync.sv
module gfm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gfm_window_fsm.sv
module gfm_window_fsm
    import gfm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_s,
    input  logic irq_both,
    output logic win_open,
    output logic win_close,
    output logic irq
);

    win_state_t state_q, state_d;
    logic       opening;
    logic       irq_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_SHUT: if (gate_s)  state_d = WIN_OPEN;
            WIN_OPEN: if (!gate_s) state_d = WIN_SHUT;
            default:               state_d = WIN_SHUT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_SHUT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        opening   = 1'b0;
        win_close = 1'b0;
        win_open  = 1'b0;
        unique case (state_q)
            WIN_SHUT: opening = gate_s;
            WIN_OPEN: begin
                win_open  = 1'b1;
                win_close = !gate_s;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= win_close | (opening & irq_both);
    end

    assign irq = irq_q;

endmodule

// File: rtl/gfm_edge_count.sv
module gfm_edge_count
    import gfm_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             edge_mode,
    input  logic             meas_s,
    input  logic             gate_s,
    input  logic             win_open,
    input  logic             win_close,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             meas_prev;
    logic             and_prev;
    logic             and_now;
    logic             inc;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;

    assign and_prev = meas_prev & win_open;
    assign and_now  = meas_s & gate_s;

    always_comb begin
        inc = 1'b0;
        unique case (edge_mode)
            MODE_AND:  inc = and_prev & !and_now;
            MODE_RISE: inc = win_close |
                             (win_open & gate_s & meas_s & !meas_prev);
            default:   inc = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_prev <= 1'b0;
            count_q   <= '0;
            ovf_q     <= 1'b0;
        end else begin
            meas_prev <= meas_s;
            if (clr) begin
                count_q <= '0;
                ovf_q   <= 1'b0;
            end else if (inc) begin
                count_q <= count_q + CNT_ONE;
                if (&count_q) ovf_q <= 1'b1;
            end
        end
    end

    assign count = count_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/gfm_counter.sv
module gfm_counter
    import gfm_pkg::*;
#(
    parameter int CNT_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_in,
    input  logic             gate_pin,
    input  logic             gate_int,
    input  logic [1:0]       gate_sel,
    input  logic             edge_mode,
    input  logic             irq_both,
    input  logic             clr,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf_flag,
    output logic             gate_lvl,
    output logic             irq
);

    logic       gate_raw;
    logic [1:0] sync_q;
    logic       meas_s;
    logic       gate_s;
    logic       win_open;
    logic       win_close;

    assign gate_raw = (gate_sel == GSEL_PIN) ? gate_pin : gate_int;

    gfm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({meas_in, gate_raw}),
        .q     (sync_q)
    );

    assign meas_s = sync_q[1];
    assign gate_s = sync_q[0];

    gfm_window_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_s    (gate_s),
        .irq_both  (irq_both),
        .win_open  (win_open),
        .win_close (win_close),
        .irq       (irq)
    );

    gfm_edge_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .edge_mode (edge_mode),
        .meas_s    (meas_s),
        .gate_s    (gate_s),
        .win_open  (win_open),
        .win_close (win_close),
        .count     (count_q),
        .ovf       (ovf_flag)
    );

    assign gate_lvl = win_open;

endmodule

// File: rtl/gfm_counter_chk.sv
module gfm_counter_chk #(
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             irq_both,
    input logic [CNT_W-1:0] count_q,
    input logic             ovf_flag,
    input logic             gate_lvl,
    input logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((count_q == $past(count_q)) || (count_q == $past(count_q) + ONE)));

    p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (&count_q)) |=> (ovf_flag || (&count_q)));

    p_ovf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr) |=> ovf_flag);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0 && !ovf_flag));

    p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_lvl && !clr) |=> $stable(count_q));

    p_close_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_lvl) |-> irq);

    p_irq_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gate_lvl != $past(gate_lvl)));

    p_open_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_lvl) && !$past(irq_both)) |-> !irq);

endmodule

bind gfm_counter gfm_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .irq_both (irq_both),
    .count_q  (count_q),
    .ovf_flag (ovf_flag),
    .gate_lvl (gate_lvl),
    .irq      (irq)
);

// File: tb/gfm_counter_tb_top.sv
`timescale 1ns/1ps
module gfm_counter_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         meas_in = 1'b0;
    logic         gate_pin = 1'b0;
    logic         gate_int = 1'b0;
    logic [1:0]   gate_sel = 2'b00;
    logic         edge_mode = 1'b0;
    logic         irq_both = 1'b0;
    logic         clr = 1'b0;
    logic [W-1:0] count_q;
    logic         ovf_flag;
    logic         gate_lvl;
    logic         irq;

    int n_vec = 0;
    int n_bad = 0;
    int irq_total = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gfm_counter #(.CNT_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_in   (meas_in),
        .gate_pin  (gate_pin),
        .gate_int  (gate_int),
        .gate_sel  (gate_sel),
        .edge_mode (edge_mode),
        .irq_both  (irq_both),
        .clr       (clr),
        .count_q   (count_q),
        .ovf_flag  (ovf_flag),
        .gate_lvl  (gate_lvl),
        .irq       (irq)
    );

    always @(negedge clk) if (irq) irq_total++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive the selected gate; the unselected source is held high
    task automatic set_gate(input bit v);
        if (gate_sel == 2'b00) begin gate_pin = v; gate_int = 1'b1; end
        else                   begin gate_int = v; gate_pin = 1'b1; end
    endtask

    task automatic do_clear();
        clr = 1'b1; tick(1); clr = 1'b0;
        exp_cnt = 0;
    endtask

    task automatic run_window(input int k, input bit hold_hi, input int plen);
        int irq0;
        irq0 = irq_total;
        if (hold_hi) meas_in = 1'b1;
        tick(4);
        set_gate(1'b1);
        tick(5);
        chk(gate_lvl == 1'b1, "R10 open", gate_lvl, 1);
        for (int i = 0; i < k; i++) begin
            meas_in = 1'b1; tick(plen);
            meas_in = 1'b0; tick(plen);
        end
        tick(4);
        set_gate(1'b0);
        tick(6);
        meas_in = 1'b0;
        tick(4);
        chk(gate_lvl == 1'b0, "R10 shut", gate_lvl, 0);
        chk(irq_total - irq0 == (irq_both ? 2 : 1), "R9 irq count",
            irq_total - irq0, irq_both ? 2 : 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk(count_q == '0 && !ovf_flag && !irq && !gate_lvl, "R3 reset state",
            int'(count_q), 0);
        rst_n = 1'b1;
        tick(2);

        // main sweep: R5 R6 R7 R8 R9 R10
        for (int sel = 0; sel < 4; sel++) begin
            gate_sel = 2'(sel);
            set_gate(1'b0);
            tick(4);
            do_clear();
            tick(1);
            for (int m = 0; m < 2; m++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int k = 0; k < 5; k++) begin
                        edge_mode = m[0];
                        irq_both  = b[0];
                        run_window(k, 1'b0, 3);
                        exp_cnt += (m == 1) ? k + 1 : k;
                        chk(int'(count_q) == exp_cnt % (1 << W),
                            m == 1 ? "R8 R5 R6 pulses" : "R7 R5 R6 pulses",
                            int'(count_q), exp_cnt % (1 << W));
                    end
                end
            end
        end

        // constant-level inputs
        gate_sel = 2'b01; irq_both = 1'b0;
        set_gate(1'b0); tick(4); do_clear(); tick(1);
        edge_mode = 1'b0; run_window(0, 1'b1, 3);
        chk(count_q == 8'd1, "R7 held high", int'(count_q), 1);
        run_window(0, 1'b0, 3);
        chk(count_q == 8'd1, "R7 held low", int'(count_q), 1);
        edge_mode = 1'b1; run_window(0, 1'b1, 3);
        chk(count_q == 8'd2, "R8 held high", int'(count_q), 2);
        run_window(0, 1'b0, 3);
        chk(count_q == 8'd3, "R8 held low", int'(count_q), 3);

        // unselected source ignored while closed: R6 R4
        gate_sel = 2'b10; gate_int = 1'b0; gate_pin = 1'b1;
        for (int i = 0; i < 6; i++) begin
            meas_in = 1'b1; tick(3); meas_in = 1'b0; tick(3);
        end
        chk(count_q == 8'd3 && !gate_lvl, "R6 R4 pin ignored", int'(count_q), 3);
        gate_sel = 2'b00; gate_pin = 1'b0; gate_int = 1'b1;
        for (int i = 0; i < 6; i++) begin
            meas_in = 1'b1; tick(3); meas_in = 1'b0; tick(3);
        end
        chk(count_q == 8'd3 && !gate_lvl, "R6 R4 internal ignored", int'(count_q), 3);

        // overflow: R1 R2
        do_clear(); tick(1);
        edge_mode = 1'b0;
        run_window((1 << W) + 3, 1'b0, 1);
        chk(count_q == 8'd3, "R1 wrap", int'(count_q), 3);
        chk(ovf_flag == 1'b1, "R2 overflow set", ovf_flag, 1);
        run_window(2, 1'b0, 3);
        chk(count_q == 8'd5, "R5 resume after wrap", int'(count_q), 5);
        chk(ovf_flag == 1'b1, "R2 overflow sticky", ovf_flag, 1);
        clr = 1'b1; tick(1); clr = 1'b0;
        chk(count_q == '0 && !ovf_flag, "R3 clear", int'(count_q), 0);

        // clear beats increment: R3
        clr = 1'b1;
        edge_mode = 1'b1;
        run_window(4, 1'b0, 3);
        clr = 1'b0;
        tick(1);
        chk(count_q == '0 && !ovf_flag, "R3 clear priority", int'(count_q), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule